// File: doc/BRIEF.md
# Iteration Count Histogram Accumulator

This block sits beside an iterative decoder. After each code word, the decoder reports how many global iterations it ran and whether the parity check passed. The block adds each report to a histogram. The regular bins are indexed by the iteration at which the check first passed. One extra bin, placed after the last regular bin, counts the code words that never passed within the reference iteration limit. The block also keeps a running total of every code word it has accepted. Reports that cannot be valid are rejected and counted separately.

A direct read port returns any single bin. A second query answers a "what if" question: how many code words would have failed if the decoder had been capped at some smaller iteration count M? To answer it, the block folds every regular bin above M into the endpoint. It does this with a sequential scan that handles one bin per clock, so no re-decoding is needed. All outputs are raw integer counts.

Top module: `iterHistAcc`

## Requirements
- R1: A valid event with the pass flag set and an iteration field i in 1..MAX_ITER increments bin i and the total by one.
- R2: A valid event with the pass flag clear increments the endpoint bin, which is index MAX_ITER+1, and the total by one. The iteration field is ignored for such events.
- R3: A valid event with the pass flag set and an iteration field of 0 or above MAX_ITER leaves every bin and the total unchanged, and increments the error counter by one.
- R4: The bin read port is combinational. Index 1..MAX_ITER returns a regular bin, index MAX_ITER+1 returns the endpoint, and index 0 or any index above MAX_ITER+1 returns 0.
- R5: As long as no counter has saturated, the total equals the sum of all regular bins plus the endpoint.
- R6: A shortened query with cap M returns the endpoint plus the sum of the regular bins with index above M. A cap of MAX_ITER or more returns the endpoint alone. A cap of 0 returns the total. A query changes neither the bins nor the total.
- R7: For a fixed histogram, the shortened result never increases as M increases.
- R8: The start request is sampled on a rising edge, called edge 0. The done flag is high for exactly the one cycle that follows edge k, where k = max(MAX_ITER−M, 0). The busy flag is high from edge 0 until done has been given.
- R9: A bin or the error counter that is at its maximum value 2^CNT_W−1 holds that value when another increment arrives, and the overflow flag is set. The overflow flag stays set until a clear. An event dropped by a saturated bin is not added to the total.
- R10: A clear request zeroes all bins, the total, the error counter and the overflow flag by the next cycle. An event in the same cycle as the clear is discarded. A scan in progress is abandoned without a done pulse.
- R11: After reset, all counts and the overflow flag are 0, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearReq | input | 1 | Synchronous clear of all counts |
| evtValid | input | 1 | Per-codeword report strobe |
| evtPass | input | 1 | Parity check passed |
| evtIter | input | ITER_W | Global iteration count at which the check passed |
| qryIdx | input | ITER_W | Bin index to read |
| qryCount | output | CNT_W | Content of the selected bin |
| totalCount | output | TOT_W | Total code words accepted |
| errCount | output | CNT_W | Rejected reports |
| overflow | output | 1 | Sticky saturation flag |
| shortStart | input | 1 | Start a shortened-endpoint query |
| shortCap | input | ITER_W | Iteration cap M for the query |
| shortBusy | output | 1 | Query in progress |
| shortDone | output | 1 | One-cycle flag: shortResult is valid |
| shortResult | output | TOT_W | Shortened endpoint |

## Verification
A clear can arrive in the same cycle as an event report. It can also arrive in the middle of a running shortened-endpoint scan. The bench forces the first case by raising clearReq and evtValid together. It then reads the target bin, the total and the error counter, and expects all of them to be zero. For the second case, the bench starts a scan with cap 0 and raises a clear two cycles later. It then expects busy to fall and no done pulse to appear over many cycles. A bin that saturates on the same edge as a new event is also checked: the bin must hold its value, the overflow flag must rise, and the total must not count the dropped event.

// File: rtl/iterHistPkg.sv
`timescale 1ns/1ps
package iterHistPkg;
  typedef struct packed {
    logic clr;
    logic bumpBin;
    logic bumpEnd;
    logic bumpErr;
    logic scanLoad;
    logic scanStep;
  } histStrobes_t;
endpackage

// File: rtl/iterHistCtrl.sv
`timescale 1ns/1ps
module iterHistCtrl
  import iterHistPkg::*;
#(
  parameter int MAX_ITER = 16,
  localparam int ITER_W = $clog2(MAX_ITER + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearReq,
  input  logic              evtValid,
  input  logic              evtPass,
  input  logic [ITER_W-1:0] evtIter,
  input  logic              shortStart,
  input  logic              ptrAbove,
  output histStrobes_t      strb,
  output logic              shortBusy,
  output logic              shortDone
);
  localparam logic [ITER_W-1:0] TOP_IDX = ITER_W'(MAX_ITER);

  typedef enum logic {ST_IDLE, ST_SCAN} scanState_t;
  scanState_t state;

  logic evtOk;
  logic evtBad;

  assign evtOk  = evtValid && !clearReq;
  assign evtBad = evtPass && ((evtIter == '0) || (evtIter > TOP_IDX));

  always_comb begin
    strb          = '0;
    strb.clr      = clearReq;
    strb.bumpBin  = evtOk && evtPass && !evtBad;
    strb.bumpEnd  = evtOk && !evtPass;
    strb.bumpErr  = evtOk && evtBad;
    strb.scanLoad = (state == ST_IDLE) && shortStart && !clearReq;
    strb.scanStep = (state == ST_SCAN) && ptrAbove && !clearReq;
  end

  assign shortBusy = (state == ST_SCAN);
  assign shortDone = (state == ST_SCAN) && !ptrAbove && !clearReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strb.scanLoad) state <= ST_SCAN;
        ST_SCAN: if (clearReq || !ptrAbove) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iterHistData.sv
`timescale 1ns/1ps
module iterHistData
  import iterHistPkg::*;
#(
  parameter int MAX_ITER = 16,
  parameter int CNT_W = 8,
  localparam int ITER_W = $clog2(MAX_ITER + 2),
  localparam int TOT_W = CNT_W + ITER_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  histStrobes_t      strb,
  input  logic [ITER_W-1:0] evtIter,
  input  logic [ITER_W-1:0] shortCap,
  input  logic [ITER_W-1:0] qryIdx,
  output logic [CNT_W-1:0]  qryCount,
  output logic [TOT_W-1:0]  totalCount,
  output logic [CNT_W-1:0]  errCount,
  output logic              overflow,
  output logic [TOT_W-1:0]  shortResult,
  output logic              ptrAbove
);
  localparam int NBINS = MAX_ITER + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] binVal [0:NBINS];
  logic [NBINS:1]   binHit;
  logic [NBINS:1]   binFull;
  logic [NBINS:1]   binBump;
  logic [ITER_W-1:0] scanPtr;
  logic [ITER_W-1:0] capReg;
  logic [CNT_W-1:0]  scanVal;
  logic              errFull;

  assign binVal[0] = '0;

  for (genvar i = 1; i <= NBINS; i++) begin : g_bin
    logic [CNT_W-1:0] cnt;
    if (i == NBINS) begin : g_end
      assign binHit[i] = strb.bumpEnd;
    end else begin : g_reg
      assign binHit[i] = strb.bumpBin && (evtIter == ITER_W'(i));
    end
    assign binFull[i] = (cnt == CNT_MAX);
    assign binBump[i] = binHit[i] && !binFull[i];
    assign binVal[i]  = cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cnt <= '0;
      else if (strb.clr)  cnt <= '0;
      else if (binBump[i]) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    qryCount = '0;
    scanVal  = '0;
    for (int k = 1; k <= NBINS; k++) begin
      if (qryIdx == ITER_W'(k)) qryCount = binVal[k];
      if (scanPtr == ITER_W'(k)) scanVal = binVal[k];
    end
  end

  assign errFull = (errCount == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      totalCount <= '0;
      errCount   <= '0;
      overflow   <= 1'b0;
    end else if (strb.clr) begin
      totalCount <= '0;
      errCount   <= '0;
      overflow   <= 1'b0;
    end else begin
      if (|binBump) totalCount <= totalCount + 1'b1;
      if (strb.bumpErr && !errFull) errCount <= errCount + 1'b1;
      if ((|(binHit & binFull)) || (strb.bumpErr && errFull)) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanPtr     <= '0;
      capReg      <= '0;
      shortResult <= '0;
    end else if (strb.scanLoad) begin
      scanPtr     <= ITER_W'(MAX_ITER);
      capReg      <= shortCap;
      shortResult <= TOT_W'(binVal[NBINS]);
    end else if (strb.scanStep) begin
      scanPtr     <= scanPtr - 1'b1;
      shortResult <= shortResult + TOT_W'(scanVal);
    end
  end

  assign ptrAbove = (scanPtr > capReg);
endmodule

// File: rtl/iterHistAcc.sv
`timescale 1ns/1ps
module iterHistAcc
  import iterHistPkg::*;
#(
  parameter int MAX_ITER = 16,
  parameter int CNT_W = 8,
  localparam int ITER_W = $clog2(MAX_ITER + 2),
  localparam int TOT_W = CNT_W + ITER_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearReq,
  input  logic              evtValid,
  input  logic              evtPass,
  input  logic [ITER_W-1:0] evtIter,
  input  logic [ITER_W-1:0] qryIdx,
  output logic [CNT_W-1:0]  qryCount,
  output logic [TOT_W-1:0]  totalCount,
  output logic [CNT_W-1:0]  errCount,
  output logic              overflow,
  input  logic              shortStart,
  input  logic [ITER_W-1:0] shortCap,
  output logic              shortBusy,
  output logic              shortDone,
  output logic [TOT_W-1:0]  shortResult
);
  histStrobes_t strb;
  logic ptrAbove;

  iterHistCtrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .evtValid(evtValid),
    .evtPass(evtPass), .evtIter(evtIter), .shortStart(shortStart),
    .ptrAbove(ptrAbove), .strb(strb), .shortBusy(shortBusy), .shortDone(shortDone)
  );

  iterHistData #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIter(evtIter), .shortCap(shortCap),
    .qryIdx(qryIdx), .qryCount(qryCount), .totalCount(totalCount),
    .errCount(errCount), .overflow(overflow), .shortResult(shortResult),
    .ptrAbove(ptrAbove)
  );
endmodule

// File: rtl/iterHistChecker.sv
`timescale 1ns/1ps
module iterHistChecker #(
  parameter int MAX_ITER = 16,
  parameter int CNT_W = 8,
  localparam int ITER_W = $clog2(MAX_ITER + 2),
  localparam int TOT_W = CNT_W + ITER_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearReq,
  input logic              evtValid,
  input logic              evtPass,
  input logic [ITER_W-1:0] evtIter,
  input logic [TOT_W-1:0]  totalCount,
  input logic [CNT_W-1:0]  errCount,
  input logic              overflow,
  input logic              shortBusy,
  input logic              shortDone,
  input logic [TOT_W-1:0]  shortResult
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (totalCount == '0 && errCount == '0 && !overflow)); // R10
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !clearReq |=> (totalCount == $past(totalCount) || totalCount == $past(totalCount) + 1'b1)); // R5
  AST_ZERO_ITER_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtPass && evtIter == '0 && !clearReq) |=> $stable(totalCount)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clearReq) |=> overflow); // R9
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    shortDone |-> shortBusy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    shortDone |=> !shortDone); // R8
  AST_SCAN_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (shortBusy && !shortDone && !clearReq) |=> shortResult >= $past(shortResult)); // R7
endmodule

bind iterHistAcc iterHistChecker #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_iterHistAcc.sv
`timescale 1ns/1ps
module test_iterHistAcc;
  localparam int MAX_ITER = 16;
  localparam int CNT_W = 8;
  localparam int ITER_W = $clog2(MAX_ITER + 2);
  localparam int TOT_W = CNT_W + ITER_W;
  localparam int NBINS = MAX_ITER + 1;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rstN = 1'b0, clearReq = 1'b0, evtValid = 1'b0, evtPass = 1'b0;
  logic [ITER_W-1:0] evtIter = '0, qryIdx = '0, shortCap = '0;
  logic shortStart = 1'b0;
  logic [CNT_W-1:0] qryCount, errCount;
  logic [TOT_W-1:0] totalCount, shortResult;
  logic overflow, shortBusy, shortDone;

  int checks = 0, errors = 0;
  int expBin [0:NBINS];
  int expErr = 0;
  int expOvf = 0;

  always #2.5 clk = ~clk;

  iterHistAcc #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) i_iterHistAcc (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int expTotal();
    int s = 0;
    for (int k = 1; k <= NBINS; k++) s += expBin[k];
    return s;
  endfunction

  function automatic int expShort(input int cap);
    int s = expBin[NBINS];
    for (int k = cap + 1; k <= MAX_ITER; k++) s += expBin[k];
    return s;
  endfunction

  task automatic modelClear();
    for (int k = 0; k <= NBINS; k++) expBin[k] = 0;
    expErr = 0; expOvf = 0;
  endtask

  task automatic sendEvt(input bit pass, input int iter);
    evtValid = 1'b1; evtPass = pass; evtIter = ITER_W'(iter);
    tick();
    evtValid = 1'b0;
    if (!pass) begin
      if (expBin[NBINS] == CMAX) expOvf = 1; else expBin[NBINS]++;
    end else if (iter == 0 || iter > MAX_ITER) begin
      if (expErr == CMAX) expOvf = 1; else expErr++;
    end else begin
      if (expBin[iter] == CMAX) expOvf = 1; else expBin[iter]++;
    end
  endtask

  task automatic checkAll(input string tag);
    for (int k = 0; k <= (1 << ITER_W) - 1; k++) begin
      qryIdx = ITER_W'(k);
      #0.1;
      check(qryCount == ((k >= 1 && k <= NBINS) ? CNT_W'(expBin[k]) : '0),
            $sformatf("%s R4 bin %0d", tag, k), qryCount, (k >= 1 && k <= NBINS) ? expBin[k] : 0);
    end
    check(totalCount == TOT_W'(expTotal()), {tag, " R5 total"}, totalCount, expTotal());
    check(errCount == CNT_W'(expErr), {tag, " R3 errCount"}, errCount, expErr);
    check(overflow == expOvf[0], {tag, " R9 overflow"}, overflow, expOvf);
  endtask

  task automatic runShort(input int cap, output int res);
    int lat = 0;
    int expLat = (MAX_ITER - cap > 0) ? MAX_ITER - cap : 0;
    shortCap = ITER_W'(cap); shortStart = 1'b1;
    tick();
    shortStart = 1'b0;
    check(shortBusy, "R8 busy after start", shortBusy, 1);
    while (!shortDone && lat < 100) begin tick(); lat++; end
    res = int'(shortResult);
    check(lat == expLat, $sformatf("R8 latency cap %0d", cap), lat, expLat);
    check(res == expShort(cap), $sformatf("R6 shortened cap %0d", cap), res, expShort(cap));
    tick();
    check(!shortDone && !shortBusy, "R8 done single cycle", shortDone, 0);
    check(totalCount == TOT_W'(expTotal()), "R6 total unchanged by query", totalCount, expTotal());
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int res, prev, seed;
    modelClear();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R11 reset state
    checkAll("R11 reset");
    check(!shortBusy && !shortDone, "R11 scan idle", shortBusy, 0);

    // directed R1 R2 R3
    sendEvt(1, 1); sendEvt(1, MAX_ITER); sendEvt(0, 0); sendEvt(0, 31);
    sendEvt(1, 0); sendEvt(1, MAX_ITER + 1); sendEvt(1, 31);
    checkAll("R1 R2 R3 directed");

    // constrained random mix
    seed = $urandom(32'h1234_5678);
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 99));
      int it;
      if (r < 70) it = int'($urandom_range(1, 6));
      else if (r < 85) it = int'($urandom_range(7, MAX_ITER));
      else it = int'($urandom_range(0, (1 << ITER_W) - 1));
      sendEvt($urandom_range(0, 9) != 0, it);
    end
    checkAll("random R1 R2 R3");

    // R6 R7 R8 shortened queries across all caps
    prev = 1 << 30;
    for (int cap = 0; cap <= MAX_ITER + 2; cap++) begin
      runShort(cap, res);
      check(res <= prev, $sformatf("R7 monotone cap %0d", cap), res, prev);
      prev = res;
    end
    runShort(0, res);
    check(res == expTotal(), "R6 cap 0 equals total", res, expTotal());

    // R10 clear with simultaneous event
    clearReq = 1'b1; evtValid = 1'b1; evtPass = 1'b1; evtIter = ITER_W'(2);
    tick();
    clearReq = 1'b0; evtValid = 1'b0;
    modelClear();
    checkAll("R10 clear with event");

    // R9 saturation
    for (int n = 0; n < CMAX + 3; n++) sendEvt(1, 3);
    checkAll("R9 saturation");
    check(totalCount == TOT_W'(CMAX), "R9 total excludes dropped", totalCount, CMAX);

    // R10 clear during scan
    clearReq = 1'b1; tick(); clearReq = 1'b0; modelClear();
    sendEvt(0, 0);
    shortCap = '0; shortStart = 1'b1; tick(); shortStart = 1'b0;
    tick();
    clearReq = 1'b1; tick(); clearReq = 1'b0; modelClear();
    begin
      int seen = 0;
      for (int n = 0; n < 30; n++) begin
        if (shortDone || shortBusy) seen++;
        tick();
      end
      check(seen == 0, "R10 scan abandoned", seen, 0);
    end
    checkAll("R10 after scan clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule